// File: doc/BRIEF.md
# Descriptor ROM Stream Checker and Entry Walker

This block inspects a descriptor ROM image as it streams past, one byte per beat on which `in_valid` is high. The final byte is marked by `in_last`. In a single pass the block does three things. It checks the header integrity fields, compares the byte count that was declared against the count actually delivered, and follows the chain of variable-length entries that begins after the header.

For every accepted port entry the block emits a one-cycle record. The record gives the port's index, its disabled flag, its link number, and its dual-link partner when one is present. The cycle after the last byte is accepted, a single `done` pulse carries the final status code and two warning flags.

Storage that holds the image, retry policy, and decoding of the text in generic entries all belong to the surrounding logic. The consumer keeps the records it has collected only when the final status is OK.

Top module: `drom_walk_check`

## Requirements
- R1: `done` pulses for exactly one cycle, in the cycle after the beat that carries `in_last`, once per image. `status` is valid with it and is encoded as 0 OK, 1 size mismatch, 2 identifier check failure, 3 chain overrun, 4 bad port entry length.
- R2: The declared image size is the 10-bit length, taken from byte 14 (low 8 bits) and bits 1:0 of byte 15, plus 13. Bits 7:2 of byte 15 are ignored. If the delivered byte count differs from the declared size, or is below 22, the status is 1. This check has the highest priority.
- R3: The CRC-8 over bytes 1 to 8 (polynomial 0x07, start value 0xFF, MSB first, no final inversion) must equal byte 0. On a mismatch the status is 2 and no record is emitted for that image.
- R4: The reflected CRC-32C (polynomial 0x82F63B78, start value all ones, final inversion) over byte 13 up to the last declared byte must equal bytes 9 to 12, read little-endian. A mismatch raises `warn_crc` with `done` and leaves the status unchanged. The flag is suppressed when the status is 1 or 2.
- R5: A revision value in byte 13 greater than 2 raises `warn_rev` with `done`.
- R6: Entries are chained from byte 22 by their length byte (entry byte 0, which counts the 2-byte entry header). Entry byte 1 holds the index in bits 5:0, port-disabled in bit 6, and the type in bit 7 (1 = port). Type-0 entries produce no record. An enabled port entry produces one record after its byte 3 is accepted: link = entry byte 2 bit 4, has-dual = entry byte 2 bit 7, partner = entry byte 3 bits 5:0. Records are never in adjacent cycles.
- R7: An entry that starts on the last declared byte, has length 0, or runs past the declared end gives status 3. No further records follow in that image.
- R8: An enabled port entry whose length is not 8 gives status 4. No further records follow in that image.
- R9: A port entry whose index is greater than `max_port` is skipped without error. An index equal to `max_port` is accepted. A disabled port entry produces a record after its byte 1, with disabled = 1 and link, has-dual and partner all 0.
- R10: Cycles with `in_valid` low change nothing. Gaps within an image give the same records and status as a stream with no gaps.
- R11: While `rst_n` is low, `done` and `rec_valid` are low and any partly received image is discarded. The next beat after reset is treated as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Image byte present this cycle |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| max_port | input | 6 | Highest port index that is accepted |
| rec_valid | output | 1 | Port record pulse |
| rec_index | output | 6 | Port index |
| rec_disabled | output | 1 | Port marked disabled |
| rec_link | output | 1 | Link number |
| rec_has_dual | output | 1 | Dual-link partner present |
| rec_partner | output | 6 | Partner port number |
| done | output | 1 | End-of-image pulse |
| status | output | 3 | Final status code |
| warn_crc | output | 1 | Payload CRC-32C mismatch |
| warn_rev | output | 1 | Revision above 2 |

## Verification
The assertions rely on three properties of the input. `max_port` stays constant while an image is streaming. Every image ends with exactly one beat carrying `in_last`. `in_last` is only ever seen together with `in_valid`. The stimulus meets all three: it changes `max_port` only in idle gaps between images, and it raises `in_last` only on a driven byte. Images are built in the bench with CRCs computed there, and each image is varied in a single field at a time (a corrupted identifier, a corrupted payload CRC, a high revision, a byte added or removed, or a bad tail entry), so every outcome traces back to one requirement.

// File: rtl/drom_walk_pkg.sv
package drom_walk_pkg;
  localparam int HDR_BYTES     = 22;  // first entry starts here
  localparam int PAYLOAD_START = 13;  // CRC-32C coverage and size bias
  localparam int UID_FIRST     = 1;
  localparam int UID_LAST      = 8;
  localparam int PCRC_FIRST    = 9;
  localparam int PCRC_LAST     = 12;
  localparam int REV_BYTE      = 13;
  localparam int LEN_LO_BYTE   = 14;
  localparam int LEN_HI_BYTE   = 15;
  localparam int PORT_BYTES    = 8;
  localparam int MAX_REV       = 2;
  localparam int IDX_BITS      = 6;

  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_SIZE     = 3'd1,
    ST_UID      = 3'd2,
    ST_OVERRUN  = 3'd3,
    ST_PORT_LEN = 3'd4
  } drom_status_e;
endpackage

// File: rtl/drom_crc_acc.sv
module drom_crc_acc #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   POLY    = 8'h07,
  parameter logic [W-1:0]   INIT    = 8'hFF,
  parameter bit             REFLECT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         reload,
  input  logic [7:0]   d,
  output logic [W-1:0] crc_nxt
);
  logic [W-1:0] crc_q;
  logic [W-1:0] stepped;

  generate
    if (REFLECT) begin : g_lsb_first
      always_comb begin
        stepped = crc_q ^ W'(d);
        for (int i = 0; i < 8; i++)
          stepped = stepped[0] ? ((stepped >> 1) ^ POLY) : (stepped >> 1);
      end
    end else begin : g_msb_first
      always_comb begin
        stepped = crc_q ^ (W'(d) << (W - 8));
        for (int i = 0; i < 8; i++)
          stepped = stepped[W-1] ? ((stepped << 1) ^ POLY) : (stepped << 1);
      end
    end
  endgenerate

  assign crc_nxt = en ? stepped : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (reload) crc_q <= INIT;
    else if (en)     crc_q <= stepped;
  end
endmodule

// File: rtl/drom_entry_walker.sv
module drom_entry_walker
  import drom_walk_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic                last,
  input  logic                run,
  input  logic [POS_W-1:0]    pos,
  input  logic [POS_W-1:0]    size,
  input  logic [7:0]          d,
  input  logic [IDX_BITS-1:0] max_port,
  output logic                rec_valid,
  output logic [IDX_BITS-1:0] rec_index,
  output logic                rec_disabled,
  output logic                rec_link,
  output logic                rec_has_dual,
  output logic [IDX_BITS-1:0] rec_partner,
  output drom_status_e        err_now
);
  localparam logic [POS_W-1:0] FIRST = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] ONE   = POS_W'(1);

  logic [POS_W-1:0] start_q, start_d, base_q, base_d, off, d_ext;
  logic [7:0]       len_q, len_d;
  logic             has_q, has_d, take_q, take_d;
  logic             link_q, link_d, dual_q, dual_d;
  logic [IDX_BITS-1:0] idx_q, idx_d;
  drom_status_e     err_q, err_d, hit;
  logic             act;
  logic             rv_d, rdis_d, rlink_d, rdual_d;
  logic [IDX_BITS-1:0] ridx_d, rpart_d;

  assign off   = pos - base_q;
  assign d_ext = POS_W'(d);
  assign act   = beat && run && (err_q == ST_OK) && (pos >= FIRST) && (pos < size);

  always_comb begin
    start_d = start_q; base_d = base_q; len_d = len_q; has_d = has_q;
    take_d = take_q; link_d = link_q; dual_d = dual_q; idx_d = idx_q;
    hit = ST_OK;
    rv_d = 1'b0; ridx_d = rec_index; rdis_d = rec_disabled;
    rlink_d = rec_link; rdual_d = rec_has_dual; rpart_d = rec_partner;
    if (act) begin
      if (pos == start_q) begin
        if ((pos + ONE == size) || (d == 8'd0) || (pos + d_ext > size))
          hit = ST_OVERRUN;
        base_d = pos; len_d = d; start_d = pos + d_ext;
        has_d = 1'b1; take_d = 1'b0;
      end else if (has_q && off == POS_W'(1)) begin
        if (d[7] && d[IDX_BITS-1:0] <= max_port) begin
          idx_d = d[IDX_BITS-1:0];
          if (d[6]) begin
            rv_d = 1'b1; ridx_d = d[IDX_BITS-1:0]; rdis_d = 1'b1;
            rlink_d = 1'b0; rdual_d = 1'b0; rpart_d = '0;
          end else if (len_q != 8'(PORT_BYTES)) begin
            hit = ST_PORT_LEN;
          end else begin
            take_d = 1'b1;
          end
        end
      end else if (has_q && take_q && off == POS_W'(2)) begin
        link_d = d[4]; dual_d = d[7];
      end else if (has_q && take_q && off == POS_W'(3)) begin
        rv_d = 1'b1; ridx_d = idx_q; rdis_d = 1'b0;
        rlink_d = link_q; rdual_d = dual_q; rpart_d = d[IDX_BITS-1:0];
        take_d = 1'b0;
      end
    end
    err_now = (hit != ST_OK) ? hit : err_q;
    err_d   = err_now;
    if (beat && last) begin
      start_d = FIRST; err_d = ST_OK; has_d = 1'b0; take_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= FIRST; base_q <= '0; len_q <= '0; has_q <= 1'b0;
      take_q <= 1'b0; link_q <= 1'b0; dual_q <= 1'b0; idx_q <= '0;
      err_q <= ST_OK; rec_valid <= 1'b0; rec_index <= '0;
      rec_disabled <= 1'b0; rec_link <= 1'b0; rec_has_dual <= 1'b0;
      rec_partner <= '0;
    end else begin
      start_q <= start_d; base_q <= base_d; len_q <= len_d; has_q <= has_d;
      take_q <= take_d; link_q <= link_d; dual_q <= dual_d; idx_q <= idx_d;
      err_q <= err_d; rec_valid <= rv_d;
      if (rv_d) begin
        rec_index <= ridx_d; rec_disabled <= rdis_d; rec_link <= rlink_d;
        rec_has_dual <= rdual_d; rec_partner <= rpart_d;
      end
    end
  end

  assert_rec_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid) else $error("back-to-back records");
  assert_rec_index_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_index <= max_port) else $error("record index above limit");
endmodule

// File: rtl/drom_walk_check.sv
module drom_walk_check
  import drom_walk_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic                in_last,
  input  logic [IDX_BITS-1:0] max_port,
  output logic                rec_valid,
  output logic [IDX_BITS-1:0] rec_index,
  output logic                rec_disabled,
  output logic                rec_link,
  output logic                rec_has_dual,
  output logic [IDX_BITS-1:0] rec_partner,
  output logic                done,
  output logic [2:0]          status,
  output logic                warn_crc,
  output logic                warn_rev
);
  localparam logic [POS_W-1:0] P_UID_HI  = POS_W'(UID_LAST);
  localparam logic [POS_W-1:0] P_UID_LO  = POS_W'(UID_FIRST);
  localparam logic [POS_W-1:0] P_PC_LO   = POS_W'(PCRC_FIRST);
  localparam logic [POS_W-1:0] P_PC_HI   = POS_W'(PCRC_LAST);
  localparam logic [POS_W-1:0] P_REV     = POS_W'(REV_BYTE);
  localparam logic [POS_W-1:0] P_LEN_LO  = POS_W'(LEN_LO_BYTE);
  localparam logic [POS_W-1:0] P_LEN_HI  = POS_W'(LEN_HI_BYTE);
  localparam logic [POS_W-1:0] P_BIAS    = POS_W'(PAYLOAD_START);
  localparam logic [POS_W-1:0] P_MIN_END = POS_W'(HDR_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d, size_q, size_d, size_now;
  logic [7:0]       ucrc_q, ucrc_d, lenlo_q, lenlo_d;
  logic [31:0]      pexp_q, pexp_d, pcrc_nxt;
  logic [7:0]       ucrc_nxt;
  logic             uid_bad_q, uid_bad_d, rev_q, rev_d;
  logic             fin, size_err, done_d, wcrc_d, wrev_d;
  drom_status_e     walk_err, status_d;

  assign fin      = in_valid && in_last;
  assign size_now = (pos_q == P_LEN_HI) ? (POS_W'({in_data[1:0], lenlo_q}) + P_BIAS) : size_q;
  assign size_err = (pos_q < P_MIN_END) || (pos_q + POS_W'(1) != size_now);

  drom_crc_acc #(.W(8), .POLY(8'h07), .INIT(8'hFF), .REFLECT(1'b0)) u_uid_crc (
    .clk(clk), .rst_n(rst_n),
    .en(in_valid && pos_q >= P_UID_LO && pos_q <= P_UID_HI),
    .reload(fin), .d(in_data), .crc_nxt(ucrc_nxt));

  drom_crc_acc #(.W(32), .POLY(32'h82F63B78), .INIT(32'hFFFFFFFF), .REFLECT(1'b1)) u_pay_crc (
    .clk(clk), .rst_n(rst_n),
    .en(in_valid && pos_q >= P_REV),
    .reload(fin), .d(in_data), .crc_nxt(pcrc_nxt));

  drom_entry_walker #(.POS_W(POS_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .last(in_last), .run(!uid_bad_q),
    .pos(pos_q), .size(size_q), .d(in_data), .max_port(max_port),
    .rec_valid(rec_valid), .rec_index(rec_index), .rec_disabled(rec_disabled),
    .rec_link(rec_link), .rec_has_dual(rec_has_dual), .rec_partner(rec_partner),
    .err_now(walk_err));

  always_comb begin
    pos_d = pos_q; size_d = size_q; ucrc_d = ucrc_q; lenlo_d = lenlo_q;
    pexp_d = pexp_q; uid_bad_d = uid_bad_q; rev_d = rev_q;
    if (in_valid) begin
      pos_d = fin ? '0 : pos_q + POS_W'(1);
      if (pos_q == '0) ucrc_d = in_data;
      if (pos_q == P_UID_HI) uid_bad_d = (ucrc_nxt != ucrc_q);
      if (pos_q >= P_PC_LO && pos_q <= P_PC_HI) pexp_d = {in_data, pexp_q[31:8]};
      if (pos_q == P_REV) rev_d = (in_data > 8'(MAX_REV));
      if (pos_q == P_LEN_LO) lenlo_d = in_data;
      if (pos_q == P_LEN_HI) size_d = size_now;
      if (fin) begin
        uid_bad_d = 1'b0; rev_d = 1'b0;
      end
    end
    done_d   = fin;
    status_d = size_err ? ST_SIZE : (uid_bad_q ? ST_UID : walk_err);
    wcrc_d   = fin && !size_err && !uid_bad_q && (~pcrc_nxt != pexp_q);
    wrev_d   = fin && rev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0; size_q <= '0; ucrc_q <= '0; lenlo_q <= '0; pexp_q <= '0;
      uid_bad_q <= 1'b0; rev_q <= 1'b0;
      done <= 1'b0; status <= ST_OK; warn_crc <= 1'b0; warn_rev <= 1'b0;
    end else begin
      pos_q <= pos_d; size_q <= size_d; ucrc_q <= ucrc_d; lenlo_q <= lenlo_d;
      pexp_q <= pexp_d; uid_bad_q <= uid_bad_d; rev_q <= rev_d;
      done <= done_d; warn_crc <= wcrc_d; warn_rev <= wrev_d;
      if (done_d) status <= status_d;
    end
  end

  assert_done_follows_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last)) else $error("done without last beat");
  assert_no_rec_after_uid_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !$past(uid_bad_q)) else $error("record after identifier failure");
endmodule

// File: tb/drom_walk_check_tb.sv
module drom_walk_check_tb;
  typedef struct packed {
    logic [3:0] kind;
    logic [5:0] maxp;
    logic [2:0] st;
    logic       wc;
    logic       wr;
    logic [3:0] nrec;
  } row_t;

  // status codes: 0 OK, 1 size, 2 uid, 3 overrun, 4 port length
  localparam row_t ROWS [12] = '{
    '{4'd0,  6'd6, 3'd0, 1'b0, 1'b0, 4'd3},
    '{4'd1,  6'd6, 3'd2, 1'b0, 1'b0, 4'd0},
    '{4'd2,  6'd6, 3'd0, 1'b1, 1'b0, 4'd3},
    '{4'd3,  6'd6, 3'd0, 1'b0, 1'b1, 4'd3},
    '{4'd4,  6'd6, 3'd1, 1'b0, 1'b0, 4'd3},
    '{4'd5,  6'd6, 3'd3, 1'b0, 1'b0, 4'd3},
    '{4'd6,  6'd6, 3'd4, 1'b0, 1'b0, 4'd3},
    '{4'd7,  6'd6, 3'd3, 1'b0, 1'b0, 4'd3},
    '{4'd8,  6'd6, 3'd3, 1'b0, 1'b0, 4'd3},
    '{4'd9,  6'd6, 3'd1, 1'b0, 1'b0, 4'd3},
    '{4'd10, 6'd1, 3'd0, 1'b0, 1'b0, 4'd1},
    '{4'd11, 6'd9, 3'd0, 1'b0, 1'b0, 4'd4}
  };

  // expected record list {index, disabled, link, has_dual, partner}
  localparam logic [14:0] EXP_REC [4] = '{
    {6'd1, 1'b0, 1'b0, 1'b1, 6'd2},
    {6'd2, 1'b0, 1'b1, 1'b1, 6'd1},
    {6'd3, 1'b1, 1'b0, 1'b0, 6'd0},
    {6'd9, 1'b0, 1'b0, 1'b0, 6'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [5:0] max_port = 6'd6;
  logic rec_valid, rec_disabled, rec_link, rec_has_dual, done, warn_crc, warn_rev;
  logic [5:0] rec_index, rec_partner;
  logic [2:0] status;

  int tests = 0, fails = 0;
  int rc = 0, dn = 0;
  logic [14:0] got_rec [8];
  logic [2:0] got_st;
  logic got_wc, got_wr;
  logic [7:0] img [0:127];
  int n, send_cnt;

  always #2.5 clk = ~clk;

  drom_walk_check u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .max_port(max_port), .rec_valid(rec_valid),
    .rec_index(rec_index), .rec_disabled(rec_disabled), .rec_link(rec_link),
    .rec_has_dual(rec_has_dual), .rec_partner(rec_partner), .done(done),
    .status(status), .warn_crc(warn_crc), .warn_rev(warn_rev));

  always @(negedge clk) begin
    if (rst_n) begin
      if (rec_valid) begin
        if (rc < 8) got_rec[rc] = {rec_index, rec_disabled, rec_link, rec_has_dual, rec_partner};
        rc = rc + 1;
      end
      if (done) begin
        dn = dn + 1; got_st = status; got_wc = warn_crc; got_wr = warn_rev;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    img[n] = b; n++;
  endtask

  task automatic build(int kind);
    logic [31:0] c32;
    logic [7:0] c8;
    logic [9:0] dlen;
    n = 0;
    for (int i = 0; i < 22; i++) put(8'h00);
    put(8'd8); put(8'h81); put(8'h80); put(8'h02); put(0); put(0); put(0); put(0);
    put(8'd8); put(8'h82); put(8'h90); put(8'h01); put(0); put(0); put(0); put(0);
    put(8'd5); put(8'h01); put(8'h41); put(8'h42); put(8'h43);
    put(8'd2); put(8'hC3);
    put(8'd8); put(8'h89); put(8'h00); put(8'h00); put(0); put(0); put(0); put(0);
    if (kind == 5) begin put(8'd0); put(8'd0); end
    if (kind == 6) begin put(8'd6); put(8'h84); put(8'h10); put(0); put(0); put(0); end
    if (kind == 7) put(8'd2);
    if (kind == 8) begin put(8'd5); put(8'h00); end
    dlen = 10'(n - 13);
    img[13] = (kind == 3) ? 8'd3 : 8'd1;
    img[14] = dlen[7:0];
    img[15] = {6'b101001, dlen[9:8]};
    img[16] = 8'h86; img[17] = 8'h80; img[18] = 8'h34; img[19] = 8'h12;
    img[20] = 8'h01; img[21] = 8'h01;
    for (int i = 1; i <= 8; i++) img[i] = 8'(8'h3C + i * 11);
    c32 = 32'hFFFFFFFF;
    for (int i = 13; i < n; i++) begin
      c32 = c32 ^ {24'h0, img[i]};
      for (int k = 0; k < 8; k++) c32 = c32[0] ? ((c32 >> 1) ^ 32'h82F63B78) : (c32 >> 1);
    end
    c32 = ~c32;
    img[9] = c32[7:0]; img[10] = c32[15:8]; img[11] = c32[23:16]; img[12] = c32[31:24];
    c8 = 8'hFF;
    for (int i = 1; i <= 8; i++) begin
      c8 = c8 ^ img[i];
      for (int k = 0; k < 8; k++) c8 = c8[7] ? ((c8 << 1) ^ 8'h07) : (c8 << 1);
    end
    img[0] = c8;
    if (kind == 1) img[3] = img[3] ^ 8'h01;
    if (kind == 2) img[9] = img[9] ^ 8'h01;
    img[n] = 8'h55;
    send_cnt = n;
    if (kind == 4) send_cnt = n + 1;
    if (kind == 9) send_cnt = n - 1;
  endtask

  task automatic send(int cnt, bit gaps);
    for (int i = 0; i < cnt; i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == cnt - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic string tag(int kind);
    case (kind)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 9: return "R2";
      5, 7, 8: return "R7";
      6: return "R8";
      10, 11: return "R9";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (10000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 done low in reset", {31'h0, done}, 0);
    chk("R11 rec_valid low in reset", {31'h0, rec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 status after reset", {29'h0, status}, 0);

    foreach (ROWS[r]) begin
      row_t row;
      row = ROWS[r];
      max_port = row.maxp;
      build(int'(row.kind));
      rc = 0; dn = 0;
      send(send_cnt, r % 2 == 1);
      chk($sformatf("R1 done count row %0d", r), dn, 1);
      chk($sformatf("%s status row %0d", tag(int'(row.kind)), r), {29'h0, got_st}, {29'h0, row.st});
      chk($sformatf("R4 warn_crc row %0d", r), {31'h0, got_wc}, {31'h0, row.wc});
      chk($sformatf("R5 warn_rev row %0d", r), {31'h0, got_wr}, {31'h0, row.wr});
      chk($sformatf("%s record count row %0d", tag(int'(row.kind)), r), rc, int'(row.nrec));
      if (r % 2 == 1)
        chk($sformatf("R10 gapped stream row %0d", r), {29'h0, got_st}, {29'h0, row.st});
      for (int i = 0; i < int'(row.nrec) && i < rc; i++)
        chk($sformatf("R6 record %0d row %0d", i, r), {17'h0, got_rec[i]}, {17'h0, EXP_REC[i]});
    end

    // R11: reset in mid-image discards partial state
    max_port = 6'd6;
    build(0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = img[i]; in_last = 1'b0;
    end
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R11 done low after mid reset", {31'h0, done}, 0);
    chk("R11 rec_valid low after mid reset", {31'h0, rec_valid}, 0);
    rst_n = 1'b1;
    rc = 0; dn = 0;
    send(send_cnt, 1'b0);
    chk("R11 status after mid reset", {29'h0, got_st}, 0);
    chk("R11 records after mid reset", rc, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule